// File: doc/BRIEF.md
# Programmable Raster Display Timing Generator

This block produces the horizontal sync, vertical sync and display-enable signals for a raster display. It counts pixel clocks across each line and counts lines across each frame. The current pixel column and row are brought out so that a pixel fetch stage elsewhere can address its source. A vertical-retrace flag tells software or a neighbouring block when the frame is in its non-display lines.

The timing is set through a one-cycle write port with nine registers. Horizontal lengths are given in 8-pixel units and stored as (pixels/8)−1. Vertical lengths are given in lines and stored as (lines)−1. A sync pulse begins after the front porch of its axis and lasts for the programmed width. The level of each sync pin depends on two things: a polarity bit in that axis's width register, and a panel-type flag. A panel that drives rows directly takes the inverse of the level used by a CRT or TFT panel.

Timing writes go to a staging copy. The staging copy moves into the working copy at the last pixel of a frame, so no frame ever mixes two parameter sets. The blank control is the one exception: it acts on the next clock, and the counters keep running while it is set.

Top module: `disp_timing_gen`

## Requirements
- R1: The column counter `px_x` counts 0, 1, 2 … up to HA+HB−1 and then returns to 0. Here HA = 8×(HACT+1) and HB = 8×(HNDP+1). HACT is bits 7:0 written at address 0, and HNDP is bits 7:0 written at address 1.
- R2: The row counter `px_y` advances by one only on the clock where `px_x` returns to 0. It counts 0 … VA+VB−1 and then returns to 0. Here VA = VACT+1 and VB = VNDP+1. VACT is bits 9:0 written at address 4, and VNDP is bits 7:0 written at address 5.
- R3: The horizontal sync is asserted while HA+8×(HSST+1) ≤ `px_x` < HA+8×(HSST+1)+8×(HSW+1). HSST is bits 7:0 at address 2, and HSW is bits 3:0 at address 3. Any part of the pulse that falls past the end of the line is cut off.
- R4: The vertical sync is asserted while VA+VSST+1 ≤ `px_y` < VA+VSST+1+VSW+1. VSST is bits 7:0 at address 6, and VSW is bits 3:0 at address 7.
- R5: The asserted level of each sync pin is its polarity bit XOR the panel flag. The polarity bit is bit 7 at address 3 for horizontal and bit 7 at address 7 for vertical. The panel flag is bit 1 at address 8. The idle level is the inverse of the asserted level.
- R6: `de` is 1 exactly when `px_x` < HA, `px_y` < VA and blank is 0.
- R7: The blank control (bit 0 at address 8) forces `de` to 0 from the clock after the write. While blank is set, the counters keep counting unchanged.
- R8: `vretrace` is 1 exactly when `px_y` ≥ VA.
- R9: A write to addresses 0–7, or to the panel flag, has no effect on the frame in progress. It takes effect from the first pixel (0,0) of the next frame.
- R10: A synchronous active-low reset sets both counters to 0 and clears blank. It loads both the staging copy and the working copy from the reset-value parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0–8) |
| wr_data | input | 10 | Register write data |
| hsync | output | 1 | Horizontal sync pin, polarity applied |
| vsync | output | 1 | Vertical sync pin, polarity applied |
| de | output | 1 | Display enable, blanking applied |
| px_x | output | 12 | Current pixel column |
| px_y | output | 11 | Current line |
| vretrace | output | 1 | 1 while in the vertical non-display lines |

## Verification
The hardest case to reach is a reprogramming write that lands in the middle of a frame. The old parameters must hold up to the last pixel, and the new ones must start exactly at (0,0). The bench runs a bench-side model of the staging and working copies. It issues a burst of writes partway through a line and checks every pixel of the remainder of that frame against the old set and every pixel of the next frame against the new one. Small configurations make this sweep exhaustive, including a sync pulse that runs past the end of the line and a vertical pulse placed beyond the frame.

// File: rtl/dtg_pkg.sv
// Package: shared field widths, register addresses and the timing
// parameter record used by the display timing generator.
package dtg_pkg;

    localparam int HF_W   = 8;   // horizontal fields, 8-pixel units
    localparam int VACT_W = 10;  // vertical active lines minus one
    localparam int VF_W   = 8;   // vertical blanking fields, lines
    localparam int SW_W   = 4;   // sync width fields
    localparam int DATA_W = 10;  // write data width
    localparam int ADDR_W = 4;   // write address width
    localparam int POL_BIT = 7;  // polarity bit inside the width registers

    typedef enum logic [ADDR_W-1:0] {
        A_HACT = 4'd0,
        A_HNDP = 4'd1,
        A_HSST = 4'd2,
        A_HSW  = 4'd3,
        A_VACT = 4'd4,
        A_VNDP = 4'd5,
        A_VSST = 4'd6,
        A_VSW  = 4'd7,
        A_CTRL = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic [HF_W-1:0]   hact;
        logic [HF_W-1:0]   hndp;
        logic [HF_W-1:0]   hsst;
        logic              hpol;
        logic [SW_W-1:0]   hsw;
        logic [VACT_W-1:0] vact;
        logic [VF_W-1:0]   vndp;
        logic [VF_W-1:0]   vsst;
        logic              vpol;
        logic [SW_W-1:0]   vsw;
        logic              panel;
    } tcfg_t;

endpackage

// File: rtl/dtg_pol.sv
// Sync pin driver: turns an internal "pulse on" flag into the pin level.
// Assumes: the asserted level is the polarity bit XOR the panel flag, and
// the idle level is its inverse.
module dtg_pol (
    input  logic on,
    input  logic pol,
    input  logic panel,
    output logic pin
);

    logic lvl;

    // asserted level for this panel class
    always_comb lvl = pol ^ panel;

    // drive asserted level while on, inverse otherwise
    always_comb pin = on ? lvl : ~lvl;

endmodule

// File: rtl/dtg_axis.sv
// One timing axis: a wrapping counter with active and sync region decode.
// Assumes: all lengths are absolute positions from count 0, are at least 1,
// and fit in LW bits; tot_len does not exceed 2**CW.
module dtg_axis #(
    parameter int CW = 12,
    parameter int LW = CW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [LW-1:0] act_len,
    input  logic [LW-1:0] tot_len,
    input  logic [LW-1:0] sync_beg,
    input  logic [LW-1:0] sync_end,
    output logic [CW-1:0] cnt,
    output logic          wrap,
    output logic          in_act,
    output logic          in_sync
);

    logic [CW-1:0] cnt_q;
    logic [LW-1:0] cnt_w;
    logic          last;

    // widen the count for comparison against lengths
    always_comb cnt_w = LW'(cnt_q);

    // last position of this axis
    always_comb last = (cnt_w == tot_len - LW'(1));

    // wrap pulse, qualified by the advance enable
    always_comb wrap = adv & last;

    // count up on advance, return to zero after the last position
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= last ? '0 : cnt_q + CW'(1);
    end

    // region decode
    always_comb begin
        in_act  = (cnt_w < act_len);
        in_sync = (cnt_w >= sync_beg) && (cnt_w < sync_end);
    end

    always_comb cnt = cnt_q;

endmodule

// File: rtl/dtg_regs.sv
// Register file: staging copy written by the port, working copy loaded
// from it at the frame boundary, and a blank bit that acts at once.
// Assumes: frame_end is a one-cycle pulse on the last pixel of a frame; a
// write on that same clock reaches the staging copy only, not the frame
// that is starting.
module dtg_regs
    import dtg_pkg::*;
#(
    parameter tcfg_t RST_CFG = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_end,
    output tcfg_t             act_cfg,
    output logic              blank
);

    tcfg_t stg_q;
    tcfg_t act_q;
    logic  blank_q;

    // staging copy: capture port writes field by field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= RST_CFG;
        end else if (wr_en) begin
            case (wr_addr)
                A_HACT: stg_q.hact <= wr_data[HF_W-1:0];
                A_HNDP: stg_q.hndp <= wr_data[HF_W-1:0];
                A_HSST: stg_q.hsst <= wr_data[HF_W-1:0];
                A_HSW: begin
                    stg_q.hpol <= wr_data[POL_BIT];
                    stg_q.hsw  <= wr_data[SW_W-1:0];
                end
                A_VACT: stg_q.vact <= wr_data[VACT_W-1:0];
                A_VNDP: stg_q.vndp <= wr_data[VF_W-1:0];
                A_VSST: stg_q.vsst <= wr_data[VF_W-1:0];
                A_VSW: begin
                    stg_q.vpol <= wr_data[POL_BIT];
                    stg_q.vsw  <= wr_data[SW_W-1:0];
                end
                A_CTRL: stg_q.panel <= wr_data[1];
                default: stg_q <= stg_q;
            endcase
        end
    end

    // blank control: takes effect on the next clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            blank_q <= 1'b0;
        else if (wr_en && (wr_addr == A_CTRL))
            blank_q <= wr_data[0];
    end

    // working copy: refreshed only at the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= RST_CFG;
        else if (frame_end)
            act_q <= stg_q;
    end

    always_comb begin
        act_cfg = act_q;
        blank   = blank_q;
    end

endmodule

// File: rtl/disp_timing_gen.sv
// Top: programmable raster timing generator. Derives absolute line and
// frame positions from the working parameter copy, runs a column axis
// every clock and a row axis on each column wrap, and applies polarity
// and blanking at the pins.
// Assumes: HCW >= 12 and VCW >= 11 so every programmable total fits.
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int                HCW       = 12,
    parameter int                VCW       = 11,
    parameter logic [HF_W-1:0]   RST_HACT  = 8'd79,
    parameter logic [HF_W-1:0]   RST_HNDP  = 8'h13,
    parameter logic [HF_W-1:0]   RST_HSST  = 8'h01,
    parameter logic              RST_HPOL  = 1'b0,
    parameter logic [SW_W-1:0]   RST_HSW   = 4'hB,
    parameter logic [VACT_W-1:0] RST_VACT  = 10'd479,
    parameter logic [VF_W-1:0]   RST_VNDP  = 8'h2C,
    parameter logic [VF_W-1:0]   RST_VSST  = 8'h09,
    parameter logic              RST_VPOL  = 1'b0,
    parameter logic [SW_W-1:0]   RST_VSW   = 4'h1,
    parameter logic              RST_PANEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [HCW-1:0]    px_x,
    output logic [VCW-1:0]    px_y,
    output logic              vretrace
);

    localparam int HLW = HCW + 2;
    localparam int VLW = VCW + 2;
    localparam int UNIT_SH = 3;   // horizontal fields count 8-pixel units

    localparam tcfg_t RST_CFG = '{
        hact: RST_HACT, hndp: RST_HNDP, hsst: RST_HSST,
        hpol: RST_HPOL, hsw: RST_HSW,
        vact: RST_VACT, vndp: RST_VNDP, vsst: RST_VSST,
        vpol: RST_VPOL, vsw: RST_VSW, panel: RST_PANEL
    };

    tcfg_t          act_cfg;
    logic           blank_q;
    logic           h_wrap, v_wrap;
    logic           h_in_act, v_in_act;
    logic           h_sync_on, v_sync_on;
    logic [HLW-1:0] h_act_len, h_tot_len, h_sb, h_se;
    logic [VLW-1:0] v_act_len, v_tot_len, v_sb, v_se;

    // parameter storage and frame-boundary update
    dtg_regs #(.RST_CFG(RST_CFG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .frame_end (v_wrap),
        .act_cfg   (act_cfg),
        .blank     (blank_q)
    );

    // horizontal positions in pixels from the 8-pixel-unit fields
    always_comb begin
        h_act_len = (HLW'(act_cfg.hact) + HLW'(1)) << UNIT_SH;
        h_tot_len = h_act_len + ((HLW'(act_cfg.hndp) + HLW'(1)) << UNIT_SH);
        h_sb      = h_act_len + ((HLW'(act_cfg.hsst) + HLW'(1)) << UNIT_SH);
        h_se      = h_sb + ((HLW'(act_cfg.hsw) + HLW'(1)) << UNIT_SH);
    end

    // vertical positions in lines from the minus-one fields
    always_comb begin
        v_act_len = VLW'(act_cfg.vact) + VLW'(1);
        v_tot_len = v_act_len + VLW'(act_cfg.vndp) + VLW'(1);
        v_sb      = v_act_len + VLW'(act_cfg.vsst) + VLW'(1);
        v_se      = v_sb + VLW'(act_cfg.vsw) + VLW'(1);
    end

    // column axis: advances every pixel clock
    dtg_axis #(.CW(HCW), .LW(HLW)) u_hax (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (1'b1),
        .act_len  (h_act_len),
        .tot_len  (h_tot_len),
        .sync_beg (h_sb),
        .sync_end (h_se),
        .cnt      (px_x),
        .wrap     (h_wrap),
        .in_act   (h_in_act),
        .in_sync  (h_sync_on)
    );

    // row axis: advances once per line
    dtg_axis #(.CW(VCW), .LW(VLW)) u_vax (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (h_wrap),
        .act_len  (v_act_len),
        .tot_len  (v_tot_len),
        .sync_beg (v_sb),
        .sync_end (v_se),
        .cnt      (px_y),
        .wrap     (v_wrap),
        .in_act   (v_in_act),
        .in_sync  (v_sync_on)
    );

    // sync pin levels per axis polarity and panel class
    dtg_pol u_hpol (
        .on    (h_sync_on),
        .pol   (act_cfg.hpol),
        .panel (act_cfg.panel),
        .pin   (hsync)
    );

    dtg_pol u_vpol (
        .on    (v_sync_on),
        .pol   (act_cfg.vpol),
        .panel (act_cfg.panel),
        .pin   (vsync)
    );

    // enable and retrace status
    always_comb begin
        de       = h_in_act & v_in_act & ~blank_q;
        vretrace = ~v_in_act;
    end

endmodule

// File: rtl/dtg_chk.sv
// Checker for disp_timing_gen: temporal properties over the counters,
// status, sync pulse and working parameter copy. Attached by bind below.
module dtg_chk
    import dtg_pkg::*;
#(
    parameter int HCW = 12,
    parameter int VCW = 11
) (
    input logic           clk,
    input logic           rst_n,
    input logic [HCW-1:0] px_x,
    input logic [VCW-1:0] px_y,
    input logic           de,
    input logic           vretrace,
    input logic           h_sync_on,
    input tcfg_t          act_cfg
);

    // R1
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((px_x == '0) || (px_x == $past(px_x) + HCW'(1))));

    // R2
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (px_x != '0) |-> $stable(px_y));

    // R3
    hsync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h_sync_on) |-> (px_x[2:0] == 3'd0));

    // R6
    de_not_retrace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> !vretrace);

    // R8
    retrace_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vretrace) |-> (px_x == '0));

    // R9
    cfg_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((px_x == '0) && (px_y == '0)) |-> $stable(act_cfg));

endmodule

bind disp_timing_gen dtg_chk #(.HCW(HCW), .VCW(VCW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .px_x      (px_x),
    .px_y      (px_y),
    .de        (de),
    .vretrace  (vretrace),
    .h_sync_on (h_sync_on),
    .act_cfg   (act_cfg)
);

// File: tb/sim_disp_timing_gen.sv
`timescale 1ns/1ps
// Bench: pixel-by-pixel sweep of small frames against an arithmetic model
// of the staging and working parameter copies.
module sim_disp_timing_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [9:0] wr_data;
    logic       hsync, vsync, de, vretrace;
    logic [11:0] px_x;
    logic [10:0] px_y;

    int checks = 0;
    int errors = 0;

    // model: index 0 hact,1 hndp,2 hsst,3 hsw,4 hpol,5 vact,6 vndp,7 vsst,8 vsw,9 vpol,10 panel
    int a[11];
    int s[11];
    int m_blank;
    int ex, ey;
    int pend, p_addr, p_data;
    int r9;

    always #4 clk = ~clk;

    disp_timing_gen #(
        .RST_HACT(8'd1), .RST_HNDP(8'd1), .RST_HSST(8'd0), .RST_HPOL(1'b1),
        .RST_HSW(4'd0), .RST_VACT(10'd3), .RST_VNDP(8'd2), .RST_VSST(8'd0),
        .RST_VPOL(1'b1), .RST_VSW(4'd0), .RST_PANEL(1'b0)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
        .px_x(px_x), .px_y(px_y), .vretrace(vretrace)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply_wr(input int addr, input int data);
        case (addr)
            0: s[0] = data & 255;
            1: s[1] = data & 255;
            2: s[2] = data & 255;
            3: begin s[4] = (data >> 7) & 1; s[3] = data & 15; end
            4: s[5] = data & 1023;
            5: s[6] = data & 255;
            6: s[7] = data & 255;
            7: begin s[9] = (data >> 7) & 1; s[8] = data & 15; end
            8: begin m_blank = data & 1; s[10] = (data >> 1) & 1; end
            default: ;
        endcase
    endtask

    // check all outputs at this negedge, then advance the model one pixel
    task automatic step();
        int hA, hT, hsb, hse, vA, vT, vsb, vse, hl, vl, last;
        string p;
        hA = 8 * (a[0] + 1);  hT = hA + 8 * (a[1] + 1);
        hsb = hA + 8 * (a[2] + 1);  hse = hsb + 8 * (a[3] + 1);
        vA = a[5] + 1;  vT = vA + a[6] + 1;
        vsb = vA + a[7] + 1;  vse = vsb + a[8] + 1;
        hl = a[4] ^ a[10];  vl = a[9] ^ a[10];
        p = r9 ? "R9 " : "";
        chk({p, "R1 px_x"}, int'(px_x), ex);
        chk({p, "R2 px_y"}, int'(px_y), ey);
        chk({p, "R3,R5 hsync"}, int'(hsync), (ex >= hsb && ex < hse) ? hl : 1 - hl);
        chk({p, "R4,R5 vsync"}, int'(vsync), (ey >= vsb && ey < vse) ? vl : 1 - vl);
        chk({p, "R6 de"}, int'(de), (ex < hA && ey < vA && m_blank == 0) ? 1 : 0);
        chk({p, "R8 vretrace"}, int'(vretrace), (ey >= vA) ? 1 : 0);
        last = (ex == hT - 1 && ey == vT - 1);
        if (ex == hT - 1) begin
            ex = 0;
            ey = (ey == vT - 1) ? 0 : ey + 1;
        end else begin
            ex++;
        end
        if (last) begin
            for (int i = 0; i < 11; i++) a[i] = s[i];
            r9 = 0;
        end
        if (pend != 0) apply_wr(p_addr, p_data);
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        wr_en = 1'b1;
        wr_addr = addr[3:0];
        wr_data = data[9:0];
        pend = 1; p_addr = addr; p_data = data;
        step();
        wr_en = 1'b0;
        pend = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic run_to(input int x, input int y);
        while (!(ex == x && ey == y)) step();
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        a = '{1, 1, 0, 0, 1, 3, 2, 0, 0, 1, 0};
        for (int i = 0; i < 11; i++) s[i] = a[i];
        m_blank = 0; ex = 0; ey = 0; pend = 0; p_addr = 0; p_data = 0; r9 = 0;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 px_x reset", int'(px_x), 0);
        chk("R10 px_y reset", int'(px_y), 0);
        chk("R10 de reset", int'(de), 1);
        chk("R10 hsync idle", int'(hsync), 0);
        chk("R10 vsync idle", int'(vsync), 0);
        chk("R10 vretrace reset", int'(vretrace), 0);
        rst_n = 1'b1;

        // two reset-configuration frames (32 x 7)
        run(2 * 224);

        // mid-frame reprogramming: old frame must finish unchanged (R9)
        run_to(5, 1);
        r9 = 1;
        wr(0, 2); wr(1, 2); wr(2, 1); wr(3, 8'h00);
        wr(4, 1); wr(5, 3); wr(6, 1); wr(7, 8'h81); wr(8, 2);
        run_to(0, 0);
        chk("R9 new frame px_x", int'(px_x), 0);
        chk("R9 new frame px_y", int'(px_y), 0);
        run(2 * 288);

        // blank acts at once, counters keep running (R7)
        run_to(3, 0);
        wr(8, 3);
        run_to(4, 0);
        chk("R7 blank de", int'(de), 0);
        chk("R7 blank px_x", int'(px_x), 4);
        run(300);
        wr(8, 2);
        run_to(4, 0);
        chk("R7 unblank de", int'(de), 1);

        // tiny frame: sync clipped at line end, vertical pulse outside frame
        r9 = 1;
        wr(0, 0); wr(1, 3); wr(2, 2); wr(3, 8'h01);
        wr(4, 0); wr(5, 0); wr(6, 0); wr(7, 8'h80); wr(8, 0);
        run_to(0, 0);
        run(3 * 80);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule